// File: doc/BRIEF.md
# Counter Slot Allocator

This block hands out slots in a bank of event counters. The bank holds a set of general-purpose slots, any of which can count any event, and up to three dedicated slots, each hard-wired to one common event: retired instructions, core clock cycles or bus clock cycles. A measurement asks for a slot by presenting its event code, a flag saying that its overflow must be delivered as a non-maskable interrupt, and the general slot it held the last time it was scheduled. One registered cycle later the allocator answers with a slot index or a busy indication, and it records the slot in a bitmap of occupied slots.

The order of preference is fixed: a dedicated slot when the event has one and that slot is free, then the request's previous general slot, then the lowest free general slot. A separate release port frees a slot when its measurement is descheduled. Both ports may be used in the same cycle. A build with no dedicated slots is a supported configuration.

Top module: `cslot_alloc`

## Requirements
- R1: After synchronous reset, no slot is marked occupied and no grant is presented.
- R2: A request without the interrupt flag whose event code is the instructions code (0xA1), the core cycles code (0xA2) or the bus cycles code (0xA3) is granted dedicated slot N_GEN+0, N_GEN+1 or N_GEN+2 respectively, when that slot is free.
- R3: A request with the non-maskable-interrupt flag set is never granted a dedicated slot. It is handled like a request for an ordinary event.
- R4: If the dedicated slot for the event is occupied, the request is granted the lowest-numbered free general slot. Its previous-slot hint is not used.
- R5: A request for an ordinary event whose previous-slot index names a free general slot (index below N_GEN) is granted that slot.
- R6: In every other case the request is granted the lowest-numbered free general slot, and the granted slot is marked occupied.
- R7: If no general slot is free for a request that needs one, the grant reports busy and no occupied bit changes.
- R8: A release with an index below N_GEN+N_FIX clears that slot's occupied bit. A release with a larger index changes nothing.
- R9: When a release and a request arrive in the same cycle, the release takes effect first, so the request may be granted the slot just freed.
- R10: The grant (valid, busy, index) and the updated bitmap appear on the outputs one clock edge after the request. In a cycle with no request, grant_valid is low in the following cycle.
- R11: With N_FIX = 0, every request, including one carrying a dedicated event code, is served from the general slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_event | input | EVT_W | Event code of the request |
| req_nmi | input | 1 | Request needs non-maskable interrupt delivery |
| req_prev | input | IDX_W | General slot the request held previously |
| rel_valid | input | 1 | Release present this cycle |
| rel_idx | input | IDX_W | Slot to free |
| grant_valid | output | 1 | A request was handled in the previous cycle |
| grant_busy | output | 1 | That request found no slot |
| grant_idx | output | IDX_W | Slot granted (meaningful when valid and not busy) |
| used_map | output | N_GEN+N_FIX | Occupied bit per slot; general slots low, dedicated slots above |

## Verification
Assertions check on every cycle that:
- a granted slot is marked occupied and was free before the grant, unless a release in the same cycle freed it;
- a busy answer only happens with all general slots occupied, and it sets no bit;
- a flagged request never lands on a dedicated slot;
- a released slot reads free afterwards, unless it was granted again at once.

The order of preference cannot be seen by these assertions and needs the bench's reference model. That order covers the dedicated slot, then the previous slot, then the lowest free slot, and the hint being skipped when the dedicated slot is taken. The model also covers the ignored out-of-range release and the build without dedicated slots.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

    // Default event codes of the three dedicated-slot events
    localparam logic [7:0] DEF_CODE_INSTR  = 8'hA1;
    localparam logic [7:0] DEF_CODE_CYCLES = 8'hA2;
    localparam logic [7:0] DEF_CODE_BUS    = 8'hA3;

    // Most dedicated slots the decoder knows about
    localparam int MAX_FIX = 3;

    // Which rule produced the decision for the current request
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_FIXED,
        SRC_PREV,
        SRC_LOW,
        SRC_BUSY
    } src_e;

    function automatic logic src_grants(input src_e s);
        return (s == SRC_FIXED) || (s == SRC_PREV) || (s == SRC_LOW);
    endfunction

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cslot_fix_decode.sv
module cslot_fix_decode import cslot_pkg::*; #(
    parameter int              N_GEN      = 4,
    parameter int              N_FIX      = 3,
    parameter int              EVT_W      = 8,
    parameter int              IDX_W      = 3,
    parameter logic [EVT_W-1:0] CODE_INSTR  = EVT_W'(DEF_CODE_INSTR),
    parameter logic [EVT_W-1:0] CODE_CYCLES = EVT_W'(DEF_CODE_CYCLES),
    parameter logic [EVT_W-1:0] CODE_BUS    = EVT_W'(DEF_CODE_BUS)
) (
    input  logic [EVT_W-1:0] event_code,
    output logic             hit,
    output logic [IDX_W-1:0] slot
);
    localparam int N_USE = min_int(N_FIX, MAX_FIX);

    generate
        if (N_USE == 0) begin : g_none
            assign hit  = 1'b0;
            assign slot = '0;
        end else begin : g_dec
            logic [EVT_W-1:0] codes [MAX_FIX];
            assign codes[0] = CODE_INSTR;
            assign codes[1] = CODE_CYCLES;
            assign codes[2] = CODE_BUS;

            always_comb begin
                hit  = 1'b0;
                slot = '0;
                for (int k = 0; k < N_USE; k++) begin
                    if (!hit && event_code == codes[k]) begin
                        hit  = 1'b1;
                        slot = IDX_W'(N_GEN + k);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cslot_low_free.sv
module cslot_low_free #(
    parameter int N   = 4,
    parameter int W   = 2
) (
    input  logic [N-1:0] free_vec,
    output logic         found,
    output logic [W-1:0] idx
);
    // Scan from the top so the lowest free index is written last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end

endmodule

// File: rtl/cslot_alloc.sv
module cslot_alloc import cslot_pkg::*; #(
    parameter int               N_GEN       = 4,
    parameter int               N_FIX       = 3,
    parameter int               EVT_W       = 8,
    parameter logic [EVT_W-1:0] CODE_INSTR  = EVT_W'(DEF_CODE_INSTR),
    parameter logic [EVT_W-1:0] CODE_CYCLES = EVT_W'(DEF_CODE_CYCLES),
    parameter logic [EVT_W-1:0] CODE_BUS    = EVT_W'(DEF_CODE_BUS),
    localparam int              N_TOT       = N_GEN + N_FIX,
    localparam int              IDX_W       = (N_TOT > 1) ? $clog2(N_TOT) : 1,
    localparam int              GW          = (N_GEN > 1) ? $clog2(N_GEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [EVT_W-1:0] req_event,
    input  logic             req_nmi,
    input  logic [IDX_W-1:0] req_prev,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             grant_valid,
    output logic             grant_busy,
    output logic [IDX_W-1:0] grant_idx,
    output logic [N_TOT-1:0] used_map
);

    logic [N_TOT-1:0] used_q, map_rel, map_nxt;
    logic             fix_hit, fix_want, rel_ok, prev_ok, low_found;
    logic [IDX_W-1:0] fix_slot, pick;
    logic [GW-1:0]    low_idx;
    src_e             src;

    cslot_fix_decode #(
        .N_GEN(N_GEN), .N_FIX(N_FIX), .EVT_W(EVT_W), .IDX_W(IDX_W),
        .CODE_INSTR(CODE_INSTR), .CODE_CYCLES(CODE_CYCLES), .CODE_BUS(CODE_BUS)
    ) u_fix (
        .event_code(req_event),
        .hit       (fix_hit),
        .slot      (fix_slot)
    );

    // Release is applied before the search sees the map
    assign rel_ok  = int'(rel_idx) < N_TOT;
    assign prev_ok = int'(req_prev) < N_GEN;

    always_comb begin
        map_rel = used_q;
        if (rel_valid && rel_ok) begin
            map_rel[rel_idx] = 1'b0;
        end
    end

    cslot_low_free #(.N(N_GEN), .W(GW)) u_low (
        .free_vec(~map_rel[N_GEN-1:0]),
        .found   (low_found),
        .idx     (low_idx)
    );

    assign fix_want = fix_hit && !req_nmi;

    always_comb begin
        src  = SRC_NONE;
        pick = '0;
        if (req_valid) begin
            if (fix_want && !map_rel[fix_slot]) begin
                src  = SRC_FIXED;
                pick = fix_slot;
            end else if (!fix_want && prev_ok && !map_rel[req_prev]) begin
                src  = SRC_PREV;
                pick = req_prev;
            end else if (low_found) begin
                src  = SRC_LOW;
                pick = IDX_W'(low_idx);
            end else begin
                src  = SRC_BUSY;
            end
        end
        map_nxt = map_rel;
        if (src_grants(src)) begin
            map_nxt[pick] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q      <= '0;
            grant_valid <= 1'b0;
            grant_busy  <= 1'b0;
            grant_idx   <= '0;
        end else begin
            used_q      <= map_nxt;
            grant_valid <= req_valid;
            grant_busy  <= (src == SRC_BUSY);
            grant_idx   <= pick;
        end
    end

    assign used_map = used_q;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic [N_TOT-1:0] map_d1;
    logic             rel_d1, rel_ok_d1, nmi_d1;
    logic [IDX_W-1:0] rel_idx_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_d1     <= '0;
            rel_d1     <= 1'b0;
            rel_ok_d1  <= 1'b0;
            rel_idx_d1 <= '0;
            nmi_d1     <= 1'b0;
        end else begin
            map_d1     <= used_q;
            rel_d1     <= rel_valid;
            rel_ok_d1  <= rel_ok;
            rel_idx_d1 <= rel_idx;
            nmi_d1     <= req_valid && req_nmi;
        end
    end

    AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_busy) |-> used_q[grant_idx]); // R6

    AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_busy) |->
            (!map_d1[grant_idx] || (rel_d1 && rel_idx_d1 == grant_idx))); // R9

    AST_BUSY_ALL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_busy) |-> (&used_q[N_GEN-1:0])); // R7

    AST_BUSY_SETS_NOTHING: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_busy) |-> ((used_q & ~map_d1) == '0)); // R7

    AST_NMI_GENERAL: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_busy && nmi_d1) |-> (int'(grant_idx) < N_GEN)); // R3

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rel_d1 && rel_ok_d1) |->
            (!used_q[rel_idx_d1] ||
             (grant_valid && !grant_busy && grant_idx == rel_idx_d1))); // R8

endmodule

// File: tb/cslot_alloc_tb.sv
`timescale 1ns/1ps
module cslot_alloc_tb_top;

    localparam int NG = 4;
    localparam logic [7:0] C_INS = 8'hA1, C_CYC = 8'hA2, C_BUS = 8'hA3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_nmi = 1'b0, rel_valid = 1'b0;
    logic [7:0] req_event = 8'h00;
    logic [2:0] req_prev = 3'd0, rel_idx = 3'd0;

    logic       gv1, gb1, gv2, gb2;
    logic [2:0] gi1;
    logic [1:0] gi2;
    logic [6:0] um1;
    logic [3:0] um2;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // model state: [instance][slot]
    bit mdl [2][8];

    always #2.5 clk = ~clk;

    cslot_alloc #(.N_GEN(NG), .N_FIX(3)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_event(req_event),
        .req_nmi(req_nmi), .req_prev(req_prev), .rel_valid(rel_valid),
        .rel_idx(rel_idx), .grant_valid(gv1), .grant_busy(gb1),
        .grant_idx(gi1), .used_map(um1));

    cslot_alloc #(.N_GEN(NG), .N_FIX(0)) dut_nf_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_event(req_event),
        .req_nmi(req_nmi), .req_prev(req_prev[1:0]), .rel_valid(rel_valid),
        .rel_idx(rel_idx[1:0]), .grant_valid(gv2), .grant_busy(gb2),
        .grant_idx(gi2), .used_map(um2));

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one instance
    task automatic model(input int m, input int nfix, input bit rq, input int ev,
                         input bit nmi, input int prv, input bit rl, input int ri,
                         output bit e_busy, output int e_idx, output string tag);
        int  ntot, k;
        bit  done_pick, fixed_taken;
        ntot = NG + nfix;
        e_busy = 0; e_idx = 0; tag = "R10";
        done_pick = 0; fixed_taken = 0;
        if (rl && ri < ntot) mdl[m][ri] = 0;
        if (rl && !rq) tag = "R8";
        if (rq) begin
            k = -1;
            if (ev == C_INS) k = 0;
            else if (ev == C_CYC) k = 1;
            else if (ev == C_BUS) k = 2;
            tag = "R6";
            if (k >= 0 && k < nfix && !nmi) begin
                if (!mdl[m][NG+k]) begin
                    e_idx = NG + k; done_pick = 1; tag = "R2";
                end else begin
                    fixed_taken = 1; tag = "R4";
                end
            end else if (k >= 0 && k < nfix && nmi) begin
                tag = "R3";
            end
            if (!done_pick && !fixed_taken && prv < NG && !mdl[m][prv]) begin
                e_idx = prv; done_pick = 1;
                if (tag == "R6") tag = "R5";
            end
            if (!done_pick) begin
                for (int i = NG - 1; i >= 0; i--)
                    if (!mdl[m][i]) begin e_idx = i; done_pick = 1; end
            end
            if (!done_pick) begin e_busy = 1; tag = "R7"; end
            else mdl[m][e_idx] = 1;
            if (rl) tag = {tag, "+R9"};
        end
        if (nfix == 0) tag = {"R11/", tag};
    endtask

    task automatic cyc(input bit rq, input logic [7:0] ev, input bit nmi,
                       input int prv, input bit rl, input int ri);
        bit    b1, b2;
        int    x1, x2;
        string t1, t2;
        logic [6:0] em1;
        logic [3:0] em2;
        req_valid = rq; req_event = ev; req_nmi = nmi;
        req_prev = 3'(prv); rel_valid = rl; rel_idx = 3'(ri);
        model(0, 3, rq, ev, nmi, prv, rl, ri, b1, x1, t1);
        model(1, 0, rq, ev, nmi, prv & 3, rl, ri & 3, b2, x2, t2);
        for (int i = 0; i < 7; i++) em1[i] = mdl[0][i];
        for (int i = 0; i < 4; i++) em2[i] = mdl[1][i];
        @(negedge clk);
        check(t1, "grant_valid", gv1, rq);
        if (rq) check(t1, "grant_busy", gb1, b1);
        if (rq && !b1) check(t1, "grant_idx", gi1, x1);
        check(t1, "used_map", um1, em1);
        check(t2, "grant_valid", gv2, rq);
        if (rq) check(t2, "grant_busy", gb2, b2);
        if (rq && !b2) check(t2, "grant_idx", gi2, x2);
        check(t2, "used_map", um2, em2);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 2; m++) for (int i = 0; i < 8; i++) mdl[m][i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "grant_valid", gv1, 0);
        check("R1", "used_map", um1, 0);
        check("R1", "used_map_nf", um2, 0);

        cyc(0, 8'h00, 0, 0, 0, 0);     // R10 idle
        cyc(1, C_INS, 0, 7, 0, 0);     // R2 -> slot 4
        cyc(1, C_CYC, 0, 7, 0, 0);     // R2 -> slot 5
        cyc(1, C_BUS, 0, 7, 0, 0);     // R2 -> slot 6
        cyc(1, C_INS, 0, 2, 0, 0);     // R4 -> lowest 0, hint ignored
        cyc(1, C_CYC, 1, 2, 0, 0);     // R3 -> general, prev 2
        cyc(1, 8'h10, 0, 3, 0, 0);     // R5 -> prev 3
        cyc(1, 8'h11, 0, 3, 0, 0);     // R6 -> lowest 1
        cyc(1, 8'h12, 0, 0, 0, 0);     // R7 busy
        cyc(0, 8'h00, 0, 0, 1, 7);     // R8 out-of-range release ignored
        cyc(0, 8'h00, 0, 0, 1, 2);     // R8 release 2
        cyc(1, 8'h12, 0, 1, 1, 1);     // R9 release then reuse 1
        cyc(1, 8'h13, 0, 3, 1, 0);     // R9 release 0, prev 3 taken -> 0
        cyc(0, 8'h00, 0, 0, 1, 4);     // R8 free dedicated slot 4
        cyc(1, C_INS, 1, 7, 0, 0);     // R3 flagged, general
        cyc(1, C_INS, 0, 7, 0, 0);     // R2 -> slot 4 again

        for (int n = 0; n < 600; n++) begin
            int   sel;
            logic [7:0] ev;
            sel = int'($urandom % 6);
            ev  = (sel == 0) ? C_INS : (sel == 1) ? C_CYC : (sel == 2) ? C_BUS
                                     : 8'($urandom % 256);
            cyc(($urandom % 3) != 0, ev, ($urandom % 4) == 0, int'($urandom % 8),
                ($urandom % 2) == 0, int'($urandom % 8));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule